// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block closes the feedback path of a frequency synthesizer that uses an external two-modulus prescaler. The prescaler divides the oscillator by either P+1 or P. It reports the end of each of its periods as a one-clock pulse on `pre_tick`. The controller answers on `mod_hi`, which selects the divisor for the prescaler's next period. It also emits `ref_pulse` once per complete division cycle, and that pulse goes to the phase comparator.

A division cycle is defined by a main count `prog_n` and a swallow count `prog_a`. The cycle opens with the prescaler dividing by P+1. Once `prog_a` prescaler periods have been seen, the swallow counter stops and the prescaler drops to P. The main counter keeps counting every prescaler period. On the `prog_n`-th period it ends the cycle, restarts both counters and takes in fresh programming.

The total oscillator-to-comparator ratio is N = (P+1)·A + (n−A)·P. To program a ratio N, use n = floor(N/P) and A = N mod P, with A < P. The controller itself does not need to know P.

Top module: `psw_divider_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_hi`, `ref_pulse` and `prog_err` are all 0. On the first clock after reset, the block latches `prog_n` and `prog_a` and opens a cycle. A `pre_tick` on that clock is not counted.
- R2: Every cycle with a latched A ≠ 0 opens with `mod_hi` = 1 (1 means divide by P+1) from the clock after the cycle start.
- R3: `mod_hi` falls on the clock after the A-th `pre_tick` of the cycle. It stays 0, and the swallow counter stays stopped, until the cycle ends.
- R4: `ref_pulse` is high for exactly one clock, on the clock after the n-th `pre_tick` of the cycle. At that same edge, both counters restart and new programming is latched.
- R5: With a prescaler that divides by P+1 while `mod_hi` = 1 and by P otherwise, consecutive `ref_pulse` rising edges are exactly (P+1)·A + (n−A)·P clocks apart.
- R6: A latched A = 0 keeps `mod_hi` at 0 for the whole cycle, giving N = n·P.
- R7: Changes on `prog_n` and `prog_a` during a cycle have no effect on that cycle. They take effect from the next cycle start.
- R8: `prog_err` is 1 exactly when the latched n is less than the latched A. In that case `mod_hi` stays 1 for the whole cycle and N = n·(P+1).
- R9: When A equals n, `mod_hi` stays 1 until the cycle ends and N = n·(P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the oscillator-rate clock seen by the prescaler) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_tick | input | 1 | One-clock pulse at the end of each prescaler period |
| prog_n | input | NW | Main count n, latched at each cycle start |
| prog_a | input | AW | Swallow count A, latched at each cycle start |
| mod_hi | output | 1 | Prescaler modulus select: 1 divides by P+1, 0 divides by P |
| ref_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| prog_err | output | 1 | Latched programming has n < A |

## Verification
Both `mod_hi` and `ref_pulse` are registered. Each is due on the clock that follows the rising edge at which the deciding `pre_tick` is taken. `prog_err` is due on the clock that follows the cycle start. The bench holds a behavioural model that is advanced on the rising edge from the same inputs, and it compares all three outputs on every falling edge. The division ratio is checked by counting clocks between successive `ref_pulse` highs, sampled at falling edges. These counts are matched against N computed from the programming that was latched when the measured cycle began. The first cycle after reset is excluded because the prescaler phase is arbitrary there.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [1:0] {
    PH_LOAD    = 2'd0,
    PH_SWALLOW = 2'd1,
    PH_MAIN    = 2'd2
  } psw_phase_e;

endpackage

// File: rtl/psw_step_cnt.sv
module psw_step_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + {{(W-1){1'b0}}, 1'b1};
  assign hit     = step && (cnt_nxt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_nxt;
  end

  // R3 / R4: a counter that is neither stepped nor cleared holds its count
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt_q));

  // R4: a clear issued by the controller always empties the count
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int NW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tick,
  input  logic [NW-1:0] prog_n,
  input  logic [AW-1:0] prog_a,
  input  logic          main_hit,
  input  logic          swal_hit,
  output logic          restart,
  output logic          main_step,
  output logic          swal_step,
  output logic [NW-1:0] live_n,
  output logic [AW-1:0] live_a,
  output logic          mod_hi,
  output logic          ref_pulse,
  output logic          prog_err
);

  localparam int CW = (NW > AW) ? NW : AW;

  psw_phase_e phase_q;
  logic [CW-1:0] n_ext;
  logic [CW-1:0] a_ext;
  logic          a_nonzero;

  assign n_ext     = CW'(prog_n);
  assign a_ext     = CW'(prog_a);
  assign a_nonzero = (prog_a != '0);

  assign restart   = (phase_q == PH_LOAD) || main_hit;
  assign main_step = pre_tick && (phase_q != PH_LOAD);
  assign swal_step = pre_tick && (phase_q == PH_SWALLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_LOAD;
      live_n    <= '0;
      live_a    <= '0;
      mod_hi    <= 1'b0;
      prog_err  <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= main_hit;
      if (restart) begin
        live_n   <= prog_n;
        live_a   <= prog_a;
        mod_hi   <= a_nonzero;
        prog_err <= (n_ext < a_ext);
        phase_q  <= a_nonzero ? PH_SWALLOW : PH_MAIN;
      end else if (swal_hit) begin
        mod_hi  <= 1'b0;
        phase_q <= PH_MAIN;
      end
    end
  end

  // R2: the divide-by-(P+1) command is raised only at a cycle start
  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> $past(restart));

  // R3: the swallow count expiring inside a cycle drops the modulus
  a_r3_drop_on_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (swal_hit && !main_hit) |=> !mod_hi);

  // R3: once in the main phase the swallow counter never reports again
  a_r3_swallow_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAIN) |-> !swal_hit);

  // R4: the main terminal count is forwarded to the comparator next clock
  a_r4_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
    main_hit |=> ref_pulse);

  // R6: a zero swallow count keeps the low modulus from the cycle start
  a_r6_zero_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (prog_a == '0)) |=> !mod_hi);

  // R7: programming is taken only at cycle starts
  a_r7_hold_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(live_n) && $stable(live_a)));

  // R8: with n < A the cycle never leaves divide-by-(P+1)
  a_r8_err_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && (phase_q != PH_LOAD)) |-> mod_hi);

endmodule

// File: rtl/psw_divider_ctrl.sv
module psw_divider_ctrl
  import psw_pkg::*;
#(
  parameter int NW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tick,
  input  logic [NW-1:0] prog_n,
  input  logic [AW-1:0] prog_a,
  output logic          mod_hi,
  output logic          ref_pulse,
  output logic          prog_err
);

  logic          restart;
  logic          main_step;
  logic          swal_step;
  logic          main_hit;
  logic          swal_hit;
  logic [NW-1:0] live_n;
  logic [AW-1:0] live_a;

  psw_ctrl #(.NW(NW), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_tick  (pre_tick),
    .prog_n    (prog_n),
    .prog_a    (prog_a),
    .main_hit  (main_hit),
    .swal_hit  (swal_hit),
    .restart   (restart),
    .main_step (main_step),
    .swal_step (swal_step),
    .live_n    (live_n),
    .live_a    (live_a),
    .mod_hi    (mod_hi),
    .ref_pulse (ref_pulse),
    .prog_err  (prog_err)
  );

  psw_step_cnt #(.W(NW)) u_main_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .step  (main_step),
    .limit (live_n),
    .hit   (main_hit)
  );

  psw_step_cnt #(.W(AW)) u_swal_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .step  (swal_step),
    .limit (live_a),
    .hit   (swal_hit)
  );

  // R1: outputs are quiet while reset is asserted
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!mod_hi && !ref_pulse && !prog_err));

endmodule

// File: tb/test_psw_divider_ctrl.sv
module test_psw_divider_ctrl;

  localparam int NW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pre_tick = 1'b0;
  logic [NW-1:0] prog_n = '0;
  logic [AW-1:0] prog_a = '0;
  logic          mod_hi;
  logic          ref_pulse;
  logic          prog_err;

  always #4 clk = ~clk;

  psw_divider_ctrl #(.NW(NW), .AW(AW)) i_psw_divider_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_tick  (pre_tick),
    .prog_n    (prog_n),
    .prog_a    (prog_a),
    .mod_hi    (mod_hi),
    .ref_pulse (ref_pulse),
    .prog_err  (prog_err)
  );

  int    checks = 0;
  int    fails = 0;
  int    psc_p = 20;
  int    pc = 0;
  int    cyc = 0;
  int    last_ref = 0;
  int    last_interval = 0;
  bit    have_prev = 0;
  string cur_tag = "R5";
  event  ref_ev;

  int    m_pulses = 0;
  int    m_n = 0;
  int    m_a = 0;
  bit    m_primed = 0;
  bit    m_fresh = 0;
  bit    exp_mod = 0;
  bit    exp_ref = 0;
  bit    exp_err = 0;
  int    nq[$];
  string tq[$];

  function automatic int div_of(int n, int a, int p);
    int k;
    k = (a < n) ? a : n;
    return (p + 1) * k + (n - k) * p;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at clock %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_load();
    m_n      = int'(prog_n);
    m_a      = int'(prog_a);
    m_pulses = 0;
    exp_mod  = (m_a != 0);
    exp_err  = (m_n < m_a);
    m_primed = 1;
    m_fresh  = 1;
    nq.push_back(div_of(m_n, m_a, psc_p));
    tq.push_back(cur_tag);
  endtask

  // behavioural reference, advanced on the rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_primed = 0;
      m_fresh  = 0;
      exp_mod  = 0;
      exp_ref  = 0;
      exp_err  = 0;
    end else begin
      exp_ref = 0;
      m_fresh = 0;
      if (!m_primed) model_load();
      else if (pre_tick) begin
        m_pulses++;
        if (m_pulses == m_n) begin
          exp_ref = 1;
          model_load();
        end else begin
          exp_mod = (m_pulses < m_a);
        end
      end
    end
  end

  // comparison, interval measurement and prescaler model on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (!rst_n) begin
      // R1: reset state
      check(!mod_hi && !ref_pulse && !prog_err, "R1", "outputs in reset",
            int'({mod_hi, ref_pulse, prog_err}), 0);
      pc        = 0;
      pre_tick  = 0;
      have_prev = 0;
      nq.delete();
      tq.delete();
    end else begin
      check(mod_hi == exp_mod, m_fresh ? "R2" : ((m_a == 0) ? "R6" : "R3"),
            "mod_hi", int'(mod_hi), int'(exp_mod));
      check(ref_pulse == exp_ref, "R4", "ref_pulse", int'(ref_pulse), int'(exp_ref));
      check(prog_err == exp_err, "R8", "prog_err", int'(prog_err), int'(exp_err));
      if (ref_pulse) begin
        int    en;
        string et;
        en = (nq.size() > 0) ? nq.pop_front() : -1;
        et = (tq.size() > 0) ? tq.pop_front() : "R4";
        if (have_prev) begin
          last_interval = cyc - last_ref;
          check(last_interval == en, et, "division ratio", last_interval, en);
        end
        have_prev = 1;
        last_ref  = cyc;
        ->ref_ev;
      end
      pc++;
      if (pc >= (mod_hi ? psc_p + 1 : psc_p)) begin
        pre_tick = 1;
        pc       = 0;
      end else begin
        pre_tick = 0;
      end
    end
  end

  task automatic start(int p, int n, int a, string tag);
    @(negedge clk);
    #1;
    rst_n   = 0;
    psc_p   = p;
    prog_n  = NW'(n);
    prog_a  = AW'(a);
    cur_tag = tag;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1;
  endtask

  task automatic wait_refs(int k);
    repeat (k) @(ref_ev);
  endtask

  initial begin
    int old_n;

    // R5: the worked example, P=20 n=1500 A=4 gives 30004
    start(20, 1500, 4, "R5");
    wait_refs(2);
    check(last_interval == 30004, "R5", "example ratio", last_interval, 30004);

    // R5: P=8 n=37 A=5 gives 301
    start(8, 37, 5, "R5");
    wait_refs(3);

    // R7: reprogram mid-cycle; the running cycle keeps the old ratio
    old_n   = div_of(37, 5, 8);
    cur_tag = "R6";
    prog_n  = NW'(20);
    prog_a  = AW'(0);
    wait_refs(1);
    check(last_interval == old_n, "R7", "ratio after mid-cycle change", last_interval, old_n);

    // R6: A=0 gives n*P = 160
    wait_refs(2);
    check(last_interval == 160, "R6", "zero swallow ratio", last_interval, 160);

    // R8: n < A flagged, whole cycle at P+1: 3*11 = 33
    start(10, 3, 7, "R8");
    wait_refs(3);
    check(prog_err == 1'b1, "R8", "prog_err flag", int'(prog_err), 1);
    check(last_interval == 33, "R8", "ratio with n<A", last_interval, 33);

    // R9: A equal to n: 6*5 = 30
    start(4, 6, 6, "R9");
    wait_refs(3);
    check(last_interval == 30, "R9", "ratio with A=n", last_interval, 30);
    check(prog_err == 1'b0, "R8", "prog_err clear with A=n", int'(prog_err), 0);

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule